// File: doc/BRIEF.md
# Paired-Register Quadword Splitter

This block sits between instruction decode and issue. It takes one decoded instruction at a time and turns each 16-byte memory instruction into two 8-byte micro-operations. A 16-byte instruction is a quadword load, store, load-reserve or store-conditional, and it names an even/odd register pair. The first micro-operation addresses the effective address. The second addresses the doubleword eight bytes above it. The byte order captured with the instruction decides which register of the pair goes with which half.

The block also checks register combinations that the architecture forbids, and catches misaligned little-endian quadword loads. Each of these cases leaves as a single flagged operation and is not split. Every other instruction passes through as one operation. Both sides use a valid/ready handshake. One output register holds the operation on offer, and a one-entry side register holds the second half of a pair.

Top module: `qpair_splitter`

## Requirements
- R1: The instruction class `in_kind` is encoded as 1 = quad load, 2 = quad store, 3 = quad load-reserve, 4 = quad store-conditional. Any other value is a plain instruction. A legal, aligned class 1..4 instruction yields exactly two output operations, in order, both with the same `out_kind`.
- R2: With `in_be` = 0 (little-endian), the first operation carries `in_rt` with bit 0 forced to 1, and the second carries `in_rt` unchanged.
- R3: With `in_be` = 1 (big-endian), the order is reversed: the first operation carries `in_rt` and the second carries `in_rt` with bit 0 forced to 1.
- R4: Both operations of a pair have `out_repeat` = 1. Only the second has `out_second` = 1 and `out_hold_irq` = 1.
- R5: The first operation's address is `in_ea` and the second's is `in_ea` + 8, modulo 2^AW.
- R6: A quad load with `in_ra` equal to `in_rt` leaves as one operation. That operation has `out_illegal` = 1, repeat, second and hold-interrupt flags clear, register `in_rt` and address `in_ea`.
- R7: A quad load-reserve with `in_ra` or `in_rb` equal to `in_rt` is flagged illegal the same way. Stores and store-conditionals are never flagged illegal.
- R8: A little-endian quad load or load-reserve with `in_ea[3:0]` non-zero leaves as one operation. That operation has `out_align` = 1, the other flags clear, register `in_rt` and address `in_ea`. The check does not apply to big-endian instructions, to stores, or to an instruction already flagged illegal.
- R9: Any other class leaves as one operation with the incoming class, register and address, and with every flag clear.
- R10: While the second operation of a pair has not yet been loaded into the output register, `in_ready` is 0. The byte order used for the second operation is the one captured with the instruction.
- R11: While `out_valid` = 1 and `out_ready` = 0, every output field holds its value. No operation is lost or repeated under any backpressure pattern.
- R12: During and straight after reset, `out_valid` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming instruction valid |
| in_ready | output | 1 | Block can take an instruction |
| in_kind | input | KW | Instruction class |
| in_rt | input | RW | Target/source register of the pair |
| in_ra | input | RW | Base register |
| in_rb | input | RW | Index register |
| in_ea | input | AW | Effective address |
| in_be | input | 1 | Big-endian mode for this instruction |
| out_valid | output | 1 | Operation valid |
| out_ready | input | 1 | Consumer takes the operation |
| out_kind | output | KW | Class of the operation |
| out_reg | output | RW | Register for this operation |
| out_addr | output | AW | Doubleword address |
| out_repeat | output | 1 | Operation is half of a pair |
| out_second | output | 1 | Operation is the second half |
| out_hold_irq | output | 1 | No asynchronous interrupt before this operation |
| out_illegal | output | 1 | Illegal register combination |
| out_align | output | 1 | Alignment exception |

## Verification
The bench builds the block with AW = 16 and RW = 5. The narrow address makes the wrap of the second doubleword past the top of the address space reachable with an effective address of 0xFFF8. The small register field makes odd and even pair numbers, and equal-register collisions, easy to set up. The bench runs the same mix of instructions under three output backpressure patterns. This exposes the pending-second path both when the consumer takes every cycle and when it stalls between the two halves.

// File: rtl/qpair_splitter.sv
module qpair_splitter #(
  parameter int AW = 64,
  parameter int RW = 5,
  parameter int KW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [KW-1:0] in_kind,
  input  logic [RW-1:0] in_rt,
  input  logic [RW-1:0] in_ra,
  input  logic [RW-1:0] in_rb,
  input  logic [AW-1:0] in_ea,
  input  logic          in_be,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [KW-1:0] out_kind,
  output logic [RW-1:0] out_reg,
  output logic [AW-1:0] out_addr,
  output logic          out_repeat,
  output logic          out_second,
  output logic          out_hold_irq,
  output logic          out_illegal,
  output logic          out_align
);
  localparam logic [KW-1:0] K_LQ   = KW'(1);
  localparam logic [KW-1:0] K_STQ  = KW'(2);
  localparam logic [KW-1:0] K_LQR  = KW'(3);
  localparam logic [KW-1:0] K_STQC = KW'(4);
  localparam logic [AW-1:0] STEP   = AW'(8);

  logic          pend;
  logic [RW-1:0] p_reg;
  logic [AW-1:0] p_addr;
  logic [KW-1:0] p_kind;

  wire slot  = !out_valid || out_ready;
  assign in_ready = !pend && slot;
  wire take  = in_valid && in_ready;

  wire is_quad = (in_kind == K_LQ) || (in_kind == K_STQ) ||
                 (in_kind == K_LQR) || (in_kind == K_STQC);
  wire is_ld   = (in_kind == K_LQ) || (in_kind == K_LQR);
  wire bad     = ((in_kind == K_LQ) && (in_ra == in_rt)) ||
                 ((in_kind == K_LQR) && ((in_ra == in_rt) || (in_rb == in_rt)));
  wire mis     = !bad && is_ld && !in_be && (in_ea[3:0] != 4'd0);
  wire split   = is_quad && !bad && !mis;

  wire [RW-1:0] odd_reg = {in_rt[RW-1:1], 1'b1};
  wire [RW-1:0] reg_a   = in_be ? in_rt : odd_reg;
  wire [RW-1:0] reg_b   = in_be ? odd_reg : in_rt;

  assign out_hold_irq = out_valid && out_repeat && out_second;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_kind    <= '0;
      out_reg     <= '0;
      out_addr    <= '0;
      out_repeat  <= 1'b0;
      out_second  <= 1'b0;
      out_illegal <= 1'b0;
      out_align   <= 1'b0;
      pend        <= 1'b0;
      p_reg       <= '0;
      p_addr      <= '0;
      p_kind      <= '0;
    end else if (slot) begin
      if (pend) begin
        out_valid   <= 1'b1;
        out_kind    <= p_kind;
        out_reg     <= p_reg;
        out_addr    <= p_addr;
        out_repeat  <= 1'b1;
        out_second  <= 1'b1;
        out_illegal <= 1'b0;
        out_align   <= 1'b0;
        pend        <= 1'b0;
      end else if (take) begin
        out_valid   <= 1'b1;
        out_kind    <= in_kind;
        out_reg     <= split ? reg_a : in_rt;
        out_addr    <= in_ea;
        out_repeat  <= split;
        out_second  <= 1'b0;
        out_illegal <= bad;
        out_align   <= mis;
        pend        <= split;
        p_reg       <= reg_b;
        p_addr      <= in_ea + STEP;
        p_kind      <= in_kind;
      end else begin
        out_valid   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qpair_splitter_chk.sv
module qpair_splitter_chk #(
  parameter int AW = 64,
  parameter int RW = 5,
  parameter int KW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [KW-1:0] out_kind,
  input logic [RW-1:0] out_reg,
  input logic [AW-1:0] out_addr,
  input logic          out_repeat,
  input logic          out_second,
  input logic          out_hold_irq,
  input logic          out_illegal,
  input logic          out_align
);
  // R5
  pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_repeat && !out_second |=>
      out_valid && out_second && out_addr == $past(out_addr) + AW'(8) &&
      out_reg[RW-1:1] == $past(out_reg[RW-1:1]) && out_kind == $past(out_kind));

  // R4
  second_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_second |-> out_repeat && out_hold_irq && !out_illegal && !out_align);

  // R8
  exc_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_repeat, out_illegal, out_align}));

  // R10
  hold_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_repeat && !out_second |-> !in_ready);

  // R11
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_kind, out_reg, out_addr, out_repeat, out_second, out_illegal, out_align}));
endmodule

bind qpair_splitter qpair_splitter_chk #(.AW(AW), .RW(RW), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_kind(out_kind), .out_reg(out_reg),
  .out_addr(out_addr), .out_repeat(out_repeat), .out_second(out_second),
  .out_hold_irq(out_hold_irq), .out_illegal(out_illegal), .out_align(out_align)
);

// File: tb/test_qpair_splitter.sv
module test_qpair_splitter;
  localparam int AW = 16;
  localparam int RW = 5;
  localparam int KW = 3;
  localparam int IW = KW + RW + AW + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_be = 1'b0, out_ready = 1'b0;
  logic [KW-1:0] in_kind = '0;
  logic [RW-1:0] in_rt = '0, in_ra = '0, in_rb = '0;
  logic [AW-1:0] in_ea = '0;
  logic in_ready, out_valid, out_repeat, out_second, out_hold_irq, out_illegal, out_align;
  logic [KW-1:0] out_kind;
  logic [RW-1:0] out_reg;
  logic [AW-1:0] out_addr;

  always #10 clk = ~clk;

  qpair_splitter #(.AW(AW), .RW(RW), .KW(KW)) i_qpair_splitter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_rt(in_rt), .in_ra(in_ra), .in_rb(in_rb),
    .in_ea(in_ea), .in_be(in_be), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_reg(out_reg), .out_addr(out_addr),
    .out_repeat(out_repeat), .out_second(out_second), .out_hold_irq(out_hold_irq),
    .out_illegal(out_illegal), .out_align(out_align)
  );

  int checks = 0, errors = 0, cyc = 0, rdy_mode = 0;
  bit done = 1'b0;
  logic [IW-1:0] exp_q[$];
  string tag_q[$];

  function automatic logic [IW-1:0] item(logic [KW-1:0] k, logic [RW-1:0] r, logic [AW-1:0] a,
                                         logic rep, logic sec, logic ill, logic al);
    return {k, r, a, rep, sec, sec, ill, al};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(logic [KW-1:0] k, logic [RW-1:0] rt, logic [RW-1:0] ra,
                      logic [RW-1:0] rb, logic [AW-1:0] ea, logic be, string req);
    logic quad, ld, bad, mis, spl;
    logic [RW-1:0] odd;
    quad = (k >= 1) && (k <= 4);
    ld   = (k == 1) || (k == 3);
    bad  = (k == 1 && ra == rt) || (k == 3 && (ra == rt || rb == rt));
    mis  = !bad && ld && !be && (ea[3:0] != 0);
    spl  = quad && !bad && !mis;
    odd  = rt | RW'(1);
    if (spl) begin
      exp_q.push_back(item(k, be ? rt : odd, ea, 1, 0, 0, 0)); tag_q.push_back(req);
      exp_q.push_back(item(k, be ? odd : rt, ea + AW'(8), 1, 1, 0, 0)); tag_q.push_back(req);
    end else begin
      exp_q.push_back(item(k, rt, ea, 0, 0, bad, mis)); tag_q.push_back(req);
    end
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_rt = rt; in_ra = ra; in_rb = rb; in_ea = ea; in_be = be;
    #5;
    while (!in_ready) begin @(negedge clk); #5; end
    @(negedge clk);
    in_valid = 1'b0;
    in_be = ~be;
    if (spl) check(in_ready == 1'b0, "R10", in_ready, 0);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      cyc++;
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3) != 0;
        default: out_ready = (cyc % 4) < 2;
      endcase
      #5;
      if (rst_n && out_valid && out_ready) begin
        logic [IW-1:0] act;
        act = {out_kind, out_reg, out_addr, out_repeat, out_second, out_hold_irq, out_illegal, out_align};
        if (exp_q.size() == 0) check(1'b0, "R11 extra op", act, 0);
        else begin
          logic [IW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(act == e, t, act, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    #5;
    // R12
    check(out_valid == 1'b0 && in_ready == 1'b1, "R12", {out_valid, in_ready}, 2'b01);
    @(negedge clk); rst_n = 1'b1;
    #5;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R12", {out_valid, in_ready}, 2'b01);
    for (int m = 0; m < 3; m++) begin
      rdy_mode = m;
      send(3'd0, 5'd9, 5'd1, 5'd2, 16'h1234, 0, "R9");
      send(3'd6, 5'd4, 5'd4, 5'd4, 16'h0007, 1, "R9");
      send(3'd1, 5'd6, 5'd3, 5'd2, 16'h0100, 0, "R1 R2");
      send(3'd1, 5'd6, 5'd3, 5'd2, 16'h0104, 1, "R3 R4");
      send(3'd2, 5'd10, 5'd10, 5'd10, 16'h0023, 0, "R8 R7 store");
      send(3'd3, 5'd8, 5'd1, 5'd8, 16'h0200, 0, "R7");
      send(3'd3, 5'd8, 5'd8, 5'd1, 16'h0200, 1, "R7");
      send(3'd1, 5'd12, 5'd12, 5'd0, 16'h0205, 0, "R6");
      send(3'd4, 5'd14, 5'd2, 5'd14, 16'h0300, 1, "R7 stcx");
      send(3'd1, 5'd2, 5'd5, 5'd0, 16'h0408, 0, "R8");
      send(3'd3, 5'd2, 5'd5, 5'd0, 16'h040C, 1, "R8 be");
      send(3'd2, 5'd20, 5'd1, 5'd1, 16'hFFF8, 0, "R5 wrap");
      send(3'd4, 5'd7, 5'd1, 5'd1, 16'h0010, 0, "R2 odd");
      send(3'd2, 5'd7, 5'd1, 5'd1, 16'h0010, 1, "R3 odd");
      send(3'd1, 5'd16, 5'd1, 5'd2, 16'h0400, 1, "R10 be held");
      send(3'd5, 5'd3, 5'd0, 5'd0, 16'h0042, 0, "R9");
    end
    rdy_mode = 0;
    repeat (10) @(negedge clk);
    #5;
    // R11
    check(exp_q.size() == 0 && out_valid == 1'b0, "R11 drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule